// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Generator

This block makes the serial clock for an SPI master, together with the two timed gaps that frame a transfer. The lead gap runs from chip-select assertion to the first clock edge. The trail gap runs from the last clock edge to chip-select release. Every interval is the product of two factors. One is a small prescaler taken from a fixed set of odd-leaning values. The other is a scaler taken from a table that is mostly powers of two. Software chooses the codes and the block only applies them.

A frame engine holds `sck_run` high while it wants clock edges. It reads the `sck_lead_stb` and `sck_trail_stb` strobes to know where each half-period ends, and it sees the clock level on `sck`. To time a gap it pulses `lead_start` or `trail_start` and waits for the matching done pulse. The parameter `MIN_DIV` sets the shortest allowed clock period in system clocks. It is 2 on faster variants and 8 on slower ones.

Top module: `spi_clk_delay_gen`

## Requirements
- R1: While reset is asserted and just after it, `sck` equals `cfg_cpol`, and both strobes and both done outputs are low.
- R2: The baud prescaler code selects a factor: 0 gives 2, 1 gives 3, 2 gives 5, 3 gives 7. The baud scaler code k selects 2, 4 or 6 for k = 0, 1, 2, and 2^k for k = 3 to 15, so code 15 gives 32768. The clock period N in system clocks is the product of the two factors.
- R3: The period is never shorter than `MIN_DIV`. When the product is below it, N = `MIN_DIV`.
- R4: Count cycles from 0, starting with the first cycle in which `sck_run` is high. Let H = ceil(N/2). `sck_lead_stb` is high in cycles where (cycle mod N) = H-1. `sck_trail_stb` is high where (cycle mod N) = N-1. `sck` is the inverse of `cfg_cpol` where (cycle mod N) ≥ H, and equals `cfg_cpol` elsewhere. With an odd N, the first half-period is therefore the longer one.
- R5: When `sck_run` is low, both strobes are low at once and `sck` returns to `cfg_cpol` by the next cycle. The next run starts again from cycle 0.
- R6: A delay prescaler code p selects the factor 2p+1 (1, 3, 5, 7). A delay scaler code k selects 2^(k+1), so 0 gives 2 and 15 gives 65536. The delay D is their product.
- R7: A start pulse in cycle t gives exactly one done pulse of one cycle in cycle t+D on the same channel.
- R8: A start given while a delay is counting restarts it from the full count, and the earlier count gives no done pulse.
- R9: No done pulse appears without a start. The lead and trail channels are independent, each using its own codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_run | input | 1 | Generate clock edges while high |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_baud_pre | input | 2 | Baud prescaler code |
| cfg_baud_scl | input | 4 | Baud scaler code |
| cfg_lead_pre | input | 2 | Lead-gap prescaler code |
| cfg_lead_scl | input | 4 | Lead-gap scaler code |
| cfg_trail_pre | input | 2 | Trail-gap prescaler code |
| cfg_trail_scl | input | 4 | Trail-gap scaler code |
| lead_start | input | 1 | Start or restart the lead gap |
| trail_start | input | 1 | Start or restart the trail gap |
| sck | output | 1 | Serial clock level |
| sck_lead_stb | output | 1 | Last cycle before the leading clock edge |
| sck_trail_stb | output | 1 | Last cycle before the trailing clock edge |
| lead_done | output | 1 | One-cycle pulse when the lead gap ends |
| trail_done | output | 1 | One-cycle pulse when the trail gap ends |

## Verification
The checker assumes two things about the inputs. First, `cfg_cpol` stays constant while `sck_run` is high. Second, the codes of a channel stay constant while that channel is counting. Its edge-to-level properties compare `sck` against the present `cfg_cpol`. The stimulus changes configuration only between runs and between delay requests, when the clock is idle and no gap is counting. Because every possible code gives a delay of at least two cycles, the done pulses can never fall on adjacent cycles, and the checker relies on this.

// File: rtl/spi_clk_delay_gen.sv
module spi_clk_delay_gen #(
  parameter int MIN_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_run,
  input  logic       cfg_cpol,
  input  logic [1:0] cfg_baud_pre,
  input  logic [3:0] cfg_baud_scl,
  input  logic [1:0] cfg_lead_pre,
  input  logic [3:0] cfg_lead_scl,
  input  logic [1:0] cfg_trail_pre,
  input  logic [3:0] cfg_trail_scl,
  input  logic       lead_start,
  input  logic       trail_start,
  output logic       sck,
  output logic       sck_lead_stb,
  output logic       sck_trail_stb,
  output logic       lead_done,
  output logic       trail_done
);
  localparam int PRE_W     = 2;
  localparam int SCL_W     = 4;
  localparam int SCL_CODES = 1 << SCL_W;
  localparam int BAUD_W    = SCL_CODES + 2;
  localparam int DLY_W     = SCL_CODES + 3;
  localparam int NCH       = 2;

  function automatic logic [BAUD_W-1:0] baud_pre_f(input logic [PRE_W-1:0] p);
    case (p)
      2'd0:    return BAUD_W'(2);
      2'd1:    return BAUD_W'(3);
      2'd2:    return BAUD_W'(5);
      default: return BAUD_W'(7);
    endcase
  endfunction

  function automatic logic [BAUD_W-1:0] baud_scl_f(input logic [SCL_W-1:0] k);
    logic [BAUD_W-1:0] kk;
    kk = BAUD_W'(k);
    if (k < SCL_W'(3)) return (kk + BAUD_W'(1)) << 1;
    return BAUD_W'(1) << k;
  endfunction

  function automatic logic [DLY_W-1:0] dly_f(input logic [PRE_W-1:0] p, input logic [SCL_W-1:0] k);
    logic [DLY_W-1:0] f;
    f = DLY_W'({p, 1'b1});
    return (f << 1) << k;
  endfunction

  logic [BAUD_W-1:0] prod, div, half1, cnt;
  logic              act;

  assign prod  = baud_pre_f(cfg_baud_pre) * baud_scl_f(cfg_baud_scl);
  assign div   = (prod < BAUD_W'(MIN_DIV)) ? BAUD_W'(MIN_DIV) : prod;
  assign half1 = (div + BAUD_W'(1)) >> 1;

  assign sck_lead_stb  = sck_run && (cnt == half1 - BAUD_W'(1));
  assign sck_trail_stb = sck_run && (cnt == div - BAUD_W'(1));
  assign sck           = act ^ cfg_cpol;

  always_ff @(posedge clk) begin
    if (!rst_n || !sck_run) begin
      cnt <= '0;
      act <= 1'b0;
    end else begin
      cnt <= sck_trail_stb ? '0 : cnt + BAUD_W'(1);
      if (sck_lead_stb)       act <= 1'b1;
      else if (sck_trail_stb) act <= 1'b0;
    end
  end

  logic [NCH-1:0][PRE_W-1:0] d_pre;
  logic [NCH-1:0][SCL_W-1:0] d_scl;
  logic [NCH-1:0]            d_start, d_done;

  assign d_pre   = {cfg_trail_pre, cfg_lead_pre};
  assign d_scl   = {cfg_trail_scl, cfg_lead_scl};
  assign d_start = {trail_start, lead_start};
  assign lead_done  = d_done[0];
  assign trail_done = d_done[1];

  for (genvar g = 0; g < NCH; g++) begin : g_dly
    logic [DLY_W-1:0] rem;
    logic             busy, done_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rem    <= '0;
        busy   <= 1'b0;
        done_r <= 1'b0;
      end else begin
        done_r <= 1'b0;
        if (d_start[g]) begin
          rem  <= dly_f(d_pre[g], d_scl[g]) - DLY_W'(2);
          busy <= 1'b1;
        end else if (busy) begin
          if (rem == '0) begin
            busy   <= 1'b0;
            done_r <= 1'b1;
          end else begin
            rem <= rem - DLY_W'(1);
          end
        end
      end
    end

    assign d_done[g] = done_r;
  end
endmodule

module spi_clk_delay_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_run,
  input logic cfg_cpol,
  input logic lead_start,
  input logic trail_start,
  input logic sck,
  input logic sck_lead_stb,
  input logic sck_trail_stb,
  input logic lead_done,
  input logic trail_done
);
  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_run |=> (sck == cfg_cpol));
  // R5
  stb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_run |-> !(sck_lead_stb || sck_trail_stb));
  // R4
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sck_lead_stb, sck_trail_stb}));
  // R4
  lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_lead_stb |=> (sck != cfg_cpol));
  // R4
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_trail_stb |=> (sck == cfg_cpol));
  // R7
  lead_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_done |=> !lead_done);
  // R7
  trail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_done |=> !trail_done);
  // R8
  lead_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_start |=> !lead_done);
  // R8
  trail_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_start |=> !trail_done);
endmodule

bind spi_clk_delay_gen spi_clk_delay_gen_chk u_chk (.*);

// File: tb/sim_spi_clk_delay_gen.sv
module sim_spi_clk_delay_gen;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, sck_run = 1'b0, cfg_cpol = 1'b0;
  logic [1:0] cfg_baud_pre = '0, cfg_lead_pre = '0, cfg_trail_pre = '0;
  logic [3:0] cfg_baud_scl = '0, cfg_lead_scl = '0, cfg_trail_scl = '0;
  logic       lead_start = 1'b0, trail_start = 1'b0;
  logic       sck, lstb, tstb, ldone, tdone;
  logic       sck8, lstb8, tstb8, ldone8, tdone8;

  spi_clk_delay_gen #(.MIN_DIV(2)) u0 (
    .clk, .rst_n, .sck_run, .cfg_cpol, .cfg_baud_pre, .cfg_baud_scl,
    .cfg_lead_pre, .cfg_lead_scl, .cfg_trail_pre, .cfg_trail_scl,
    .lead_start, .trail_start, .sck(sck), .sck_lead_stb(lstb),
    .sck_trail_stb(tstb), .lead_done(ldone), .trail_done(tdone));

  spi_clk_delay_gen #(.MIN_DIV(8)) u1 (
    .clk, .rst_n, .sck_run, .cfg_cpol, .cfg_baud_pre, .cfg_baud_scl,
    .cfg_lead_pre, .cfg_lead_scl, .cfg_trail_pre, .cfg_trail_scl,
    .lead_start, .trail_start, .sck(sck8), .sck_lead_stb(lstb8),
    .sck_trail_stb(tstb8), .lead_done(ldone8), .trail_done(tdone8));

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bpre(input int p);
    case (p) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction

  function automatic int bscl(input int k);
    return (k < 3) ? 2 * (k + 1) : (1 << k);
  endfunction

  function automatic int expv(input int i, input int n, input bit pol);
    int h, m;
    h = (n + 1) / 2;
    m = i % n;
    return {(m >= h) ? ~pol : pol, m == h - 1, m == n - 1};
  endfunction

  // R2 R3 R4 R5
  task automatic run_baud(input int p, input int k, input bit pol);
    int n0, n1, f0, f1, a0, e0, a1, e1, cyc;
    n0 = bpre(p) * bscl(k); if (n0 < 2) n0 = 2;
    n1 = bpre(p) * bscl(k); if (n1 < 8) n1 = 8;
    cyc = 2 * n1 + 2;
    f0 = -1; f1 = -1; a0 = 0; e0 = 0; a1 = 0; e1 = 0;
    @(negedge clk);
    cfg_baud_pre = 2'(p); cfg_baud_scl = 4'(k); cfg_cpol = pol;
    @(negedge clk);
    sck_run = 1'b1;
    for (int i = 0; i < cyc; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (f0 < 0 && int'({sck, lstb, tstb}) != expv(i, n0, pol)) begin
        f0 = i; a0 = int'({sck, lstb, tstb}); e0 = expv(i, n0, pol);
      end
      if (f1 < 0 && int'({sck8, lstb8, tstb8}) != expv(i, n1, pol)) begin
        f1 = i; a1 = int'({sck8, lstb8, tstb8}); e1 = expv(i, n1, pol);
      end
    end
    check(f0 < 0, "R2 R4 clock pattern {sck,lead,trail}", a0, e0);
    check(f1 < 0, "R3 clamped clock pattern {sck,lead,trail}", a1, e1);
    @(negedge clk);
    sck_run = 1'b0;
    #1;
    check(!lstb && !tstb && !lstb8 && !tstb8, "R5 strobes low when stopped",
          int'({lstb, tstb, lstb8, tstb8}), 0);
    @(negedge clk); #1;
    check(sck == pol && sck8 == pol, "R5 idle level", int'({sck, sck8}), pol ? 3 : 0);
  endtask

  // R6 R7 R9
  task automatic run_dly(input int ch, input int p, input int k);
    int d, f, a, e;
    d = (2 * p + 1) << (k + 1);
    f = -1; a = 0; e = 0;
    @(negedge clk);
    if (ch == 0) begin cfg_lead_pre = 2'(p); cfg_lead_scl = 4'(k); lead_start = 1'b1; end
    else begin cfg_trail_pre = 2'(p); cfg_trail_scl = 4'(k); trail_start = 1'b1; end
    for (int i = 0; i <= d + 3; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) begin lead_start = 1'b0; trail_start = 1'b0; end
      #1;
      if (f < 0 && int'({ldone, tdone}) != ((i == d) ? (ch == 0 ? 2 : 1) : 0)) begin
        f = i; a = int'({ldone, tdone}); e = (i == d) ? (ch == 0 ? 2 : 1) : 0;
      end
    end
    check(f < 0, ch == 0 ? "R6 R7 R9 lead gap {lead,trail}" : "R6 R7 R9 trail gap {lead,trail}", a, e);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lpos, tpos, dpos, f;
    repeat (3) @(negedge clk);
    #1;
    check(sck == 1'b0 && !lstb && !tstb && !ldone && !tdone, "R1 reset state cpol=0",
          int'({sck, lstb, tstb, ldone, tdone}), 0);
    cfg_cpol = 1'b1; #1;
    check(sck == 1'b1 && sck8 == 1'b1, "R1 reset level follows cpol=1", int'({sck, sck8}), 3);
    @(negedge clk); rst_n = 1'b1; cfg_cpol = 1'b0;
    @(negedge clk); #1;
    check(!lstb && !tstb && !ldone && !tdone && sck == 1'b0, "R1 after reset",
          int'({sck, lstb, tstb, ldone, tdone}), 0);

    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 6; k++)
        for (int pol = 0; pol < 2; pol++)
          run_baud(p, k, pol[0]);

    // R2 top scaler code: N = 2 * 32768
    @(negedge clk); cfg_baud_pre = 2'd0; cfg_baud_scl = 4'd15; cfg_cpol = 1'b0;
    @(negedge clk); sck_run = 1'b1;
    lpos = -1; tpos = -1;
    for (int i = 0; i < 65540 && tpos < 0; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      if (lstb && lpos < 0) lpos = i;
      if (tstb && tpos < 0) tpos = i;
    end
    check(lpos == 32767, "R2 R4 code 15 leading strobe cycle", lpos, 32767);
    check(tpos == 65535, "R2 R4 code 15 trailing strobe cycle", tpos, 65535);
    @(negedge clk); sck_run = 1'b0;

    // R9 nothing without a request
    f = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (ldone || tdone) f++;
    end
    check(f == 0, "R9 no done without start", f, 0);

    for (int ch = 0; ch < 2; ch++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++)
          run_dly(ch, p, k);

    // R8 restart: D = 16, start at 0 and 5, done only at 21
    @(negedge clk); cfg_lead_pre = 2'd0; cfg_lead_scl = 4'd3; lead_start = 1'b1;
    f = 0; dpos = -1;
    for (int i = 0; i < 30; i++) begin
      if (i > 0) @(negedge clk);
      lead_start = (i == 0 || i == 5);
      #1;
      if (ldone) begin f++; if (dpos < 0) dpos = i; end
    end
    lead_start = 1'b0;
    check(dpos == 21 && f == 1, "R8 restart first done cycle", dpos, 21);

    // R6 top scaler code: D = 1 * 65536
    @(negedge clk); cfg_trail_pre = 2'd0; cfg_trail_scl = 4'd15; trail_start = 1'b1;
    dpos = -1;
    for (int i = 0; i < 65540 && dpos < 0; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) trail_start = 1'b0;
      #1;
      if (tdone) dpos = i;
    end
    check(dpos == 65536, "R6 code 15 trail gap length", dpos, 65536);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule